// File: doc/BRIEF.md
# Circular Auto-Buffer Address Generator

This block produces the memory-side address sequence for one DMA channel that runs a circular buffer without ever stopping. The other side of each transfer is a fixed peripheral location, so the block gives it only a one-cycle strobe per element. The memory side walks through N elements that start at a base address. The base is aligned to a power of two 2^r with 2^r greater than N, which keeps every address inside that aligned window. Each element is started by one peripheral sync event, for example a serial receiver reporting that a word is ready. The data itself is moved by other logic.

The block is built for ping-pong processing. A pass counter tracks how many elements of the current pass are done. When the half point or the end of the buffer is reached, an interrupt can be raised, and a flag reports which half has just been completed. Software can then process that half while the other half fills. The offset can step upward or downward. Dropping the enable freezes the sequence and rewinds the block, so the next enabled run starts again at offset 0.

Top module: `cab_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, fixed_stb and irq are 0, half_done is 0 and mem_addr is 0.
- R2: A cycle with enable=1 and sync_evt=1 produces exactly one fixed_stb pulse on the next clock. In that same cycle mem_addr = buf_base + offset, where offset is the element position at the time of the sync. A cycle without an enabled sync produces no strobe.
- R3: With step_down=0 the offset sequence is 0, 1, ..., N-1 and then returns to 0, repeating without end.
- R4: With step_down=1 the sequence starts at offset 0, then goes to N-1, and counts down to 1 before it returns to 0.
- R5: With irq_mode=0, irq pulses together with the strobe of the element that completes the pass (the N-th element of the pass) and at no other time.
- R6: With irq_mode=1, irq also pulses with the strobe of element number floor(N/2) of each pass.
- R7: half_done changes to 0 on the strobe of the element that completes the first half (element floor(N/2)). It changes to 1 on the strobe of the element that completes the pass. At all other times it holds its value, whatever irq_mode is.
- R8: While enable=0, sync_evt is ignored: no strobe and no irq appear. The offset and the pass count return to 0 and half_done is cleared to 0, so the next enabled sync uses offset 0.
- R9: Every strobed mem_addr lies in the range from buf_base to buf_base+N-1. The block supports N from 2 to 2^CNT_W-1, and buf_base, buf_size, step_down and irq_mode are changed only while enable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable; low rewinds the buffer position |
| sync_evt | input | 1 | Peripheral event that starts one element |
| buf_base | input | ADDR_W | Buffer base, aligned to a power of two larger than N |
| buf_size | input | CNT_W | Buffer length N in elements |
| step_down | input | 1 | 0 steps the offset +1, 1 steps it -1 |
| irq_mode | input | 1 | 0 interrupts at full only, 1 at half and full |
| mem_addr | output | ADDR_W | Memory address of the strobed element |
| fixed_stb | output | 1 | One-cycle strobe toward the fixed peripheral side |
| irq | output | 1 | Half/full buffer interrupt pulse |
| half_done | output | 1 | 0 after the first half completes, 1 after the second |

## Verification
The sequence is first run upward on an even buffer of 8 in full-only interrupt mode for more than two passes. This separates a correct wrap to the base from an overrun, and a full interrupt from a spurious half interrupt. An odd buffer of 5 stepping downward with back-to-back syncs in half-and-full mode shows whether the wrap from 0 to N-1 is right and whether the half point falls on floor(N/2). An even buffer in half-and-full mode at a second base shows whether both interrupts and the flag toggle land on the right elements. A disable in the middle of a pass, with syncs sent while disabled, shows whether events are ignored and whether the next run restarts at offset 0 with the flag cleared.

// File: rtl/cab_pkg.sv
package cab_pkg;
  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_e;
endpackage

// File: rtl/cab_offset_step.sv
module cab_offset_step
  import cab_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cur_off,
  input  logic [CNT_W-1:0] buf_size,
  input  step_e            dir,
  output logic [CNT_W-1:0] nxt_off
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] last_off;

  always_comb begin
    last_off = buf_size - ONE;
    nxt_off  = cur_off;
    unique case (dir)
      STEP_UP: begin
        if (cur_off >= last_off) nxt_off = ZERO;
        else                     nxt_off = cur_off + ONE;
      end
      STEP_DOWN: begin
        if (cur_off == ZERO)     nxt_off = last_off;
        else if (cur_off > last_off) nxt_off = last_off;
        else                     nxt_off = cur_off - ONE;
      end
      default: nxt_off = ZERO;
    endcase
  end
endmodule

// File: rtl/cab_progress.sv
module cab_progress #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] buf_size,
  output logic             half_hit,
  output logic             full_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] half_pt;
  logic             cnt_en;

  // next-state
  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    half_pt  = buf_size >> 1;
    half_hit = adv && (half_pt != '0) && (cnt_inc == {1'b0, half_pt});
    full_hit = adv && (cnt_inc >= {1'b0, buf_size});
    cnt_en   = clr || adv;
    if (clr)           cnt_d = '0;
    else if (full_hit) cnt_d = '0;
    else               cnt_d = cnt_inc[CNT_W-1:0];
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  // pass count never leaves 0..N-1 while running
  prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv) |=> (cnt_q < buf_size));

  // R8
  // a clear rewinds the pass count
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/cab_addr_gen.sv
module cab_addr_gen
  import cab_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter bit ALIGN_OR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_evt,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [CNT_W-1:0]  buf_size,
  input  logic              step_down,
  input  logic              irq_mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fixed_stb,
  output logic              irq,
  output logic              half_done
);
  localparam int PAD_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0]  off_q, off_d, off_step;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_cmb;
  logic [ADDR_W-1:0] off_ext;
  logic              stb_q, stb_d;
  logic              irq_q, irq_d;
  logic              half_q, half_d;
  logic              go;
  logic              clr;
  logic              half_hit, full_hit;
  logic              off_en, addr_en, half_en;
  step_e             dir;

  assign dir     = step_e'(step_down);
  assign go      = enable && sync_evt;
  assign clr     = !enable;
  assign off_ext = {{PAD_W{1'b0}}, off_q};

  cab_offset_step #(.CNT_W(CNT_W)) u_step (
    .cur_off  (off_q),
    .buf_size (buf_size),
    .dir      (dir),
    .nxt_off  (off_step)
  );

  cab_progress #(.CNT_W(CNT_W)) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (go),
    .buf_size (buf_size),
    .half_hit (half_hit),
    .full_hit (full_hit)
  );

  generate
    if (ALIGN_OR) begin : g_addr_or
      assign addr_cmb = buf_base | off_ext;
    end else begin : g_addr_add
      assign addr_cmb = buf_base + off_ext;
    end
  endgenerate

  // next-state
  always_comb begin
    off_en  = clr || go;
    off_d   = clr ? '0 : off_step;
    addr_en = go;
    addr_d  = addr_cmb;
    stb_d   = go;
    irq_d   = full_hit || (irq_mode && half_hit);
    half_en = clr || half_hit || full_hit;
    if (clr)           half_d = 1'b0;
    else if (full_hit) half_d = 1'b1;
    else               half_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (half_en) half_q <= half_d;
  end

  assign mem_addr  = addr_q;
  assign fixed_stb = stb_q;
  assign irq       = irq_q;
  assign half_done = half_q;

  // R2
  stb_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sync_evt) |=> fixed_stb);

  // R2
  no_stb_without_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && sync_evt) |=> !fixed_stb);

  // R9
  addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_stb |-> ((mem_addr - buf_base) < {{PAD_W{1'b0}}, buf_size}));

  // R5
  irq_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fixed_stb);

  // R5
  full_only_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq_mode)) |-> half_done);

  // R8
  rewind_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (off_q == '0 && !half_done));

  // R7
  flag_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sync_evt) |=> $stable(half_done));
endmodule

// File: tb/sim_cab_addr_gen.sv
module sim_cab_addr_gen;
  localparam int AW = 16;
  localparam int CW = 8;

  typedef struct packed {
    logic [AW-1:0] a;
    logic          i;
    logic          h;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          sync_evt = 1'b0;
  logic [AW-1:0] buf_base = '0;
  logic [CW-1:0] buf_size = CW'(8);
  logic          step_down = 1'b0;
  logic          irq_mode = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          fixed_stb;
  logic          irq;
  logic          half_done;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R2";
  exp_t  q[$];
  int    m_off = 0;
  int    m_prog = 0;
  logic  m_half = 1'b0;
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  cab_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_evt(sync_evt),
    .buf_base(buf_base), .buf_size(buf_size), .step_down(step_down),
    .irq_mode(irq_mode), .mem_addr(mem_addr), .fixed_stb(fixed_stb),
    .irq(irq), .half_done(half_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: models one element and issues its sync (called at a negedge)
  task automatic pulse();
    exp_t e;
    int   n;
    int   pn;
    bit   hh, ff;
    n  = int'(buf_size);
    pn = m_prog + 1;
    hh = (n / 2 != 0) && (pn == n / 2);
    ff = (pn == n);
    if (ff) m_half = 1'b1;
    else if (hh) m_half = 1'b0;
    e.a = buf_base + AW'(m_off);
    e.i = ff || (irq_mode && hh);
    e.h = m_half;
    q.push_back(e);
    m_prog = ff ? 0 : pn;
    if (step_down) m_off = (m_off == 0) ? n - 1 : m_off - 1;
    else           m_off = (m_off == n - 1) ? 0 : m_off + 1;
    sync_evt = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0;
  endtask

  task automatic gap(input int cyc);
    for (int k = 0; k < cyc; k++) @(negedge clk);
  endtask

  task automatic run_off();
    enable = 1'b0;
    m_off  = 0;
    m_prog = 0;
    m_half = 1'b0;
    @(posedge clk); #5;
    // R8: flag cleared by disable
    check(half_done == 1'b0, "R8", "half_done after disable", half_done, 0);
    @(negedge clk);
  endtask

  // sync while disabled: observed at the ports, must give nothing
  task automatic dead_pulse();
    sync_evt = 1'b1;
    @(posedge clk); #5;
    check(fixed_stb == 1'b0 && irq == 1'b0, "R8", "strobe while disabled",
          {fixed_stb, irq}, 0);
    @(negedge clk);
    sync_evt = 1'b0;
    @(posedge clk); #5;
    check(fixed_stb == 1'b0, "R8", "strobe after disabled sync", fixed_stb, 0);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (fixed_stb) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(mem_addr == e.a, tag, "mem_addr", mem_addr, e.a);
          check(irq == e.i, irq_mode ? "R6" : "R5", "irq", irq, e.i);
          check(half_done == e.h, "R7", "half_done", half_done, e.h);
        end
      end else if (irq) begin
        check(1'b0, "R5", "irq without strobe", 1, 0);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    gap(3);
    #15;
    // R1: outputs quiet in reset
    check(fixed_stb == 0 && irq == 0 && half_done == 0 && mem_addr == 0,
          "R1", "reset outputs", {mem_addr, fixed_stb, irq, half_done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check(fixed_stb == 0 && irq == 0 && half_done == 0 && mem_addr == 0,
          "R1", "outputs after release", {mem_addr, fixed_stb, irq, half_done}, 0);
    @(negedge clk);

    // R3 R5: upward, N=8, full-only irq, spaced syncs, over two passes
    tag = "R3"; buf_base = 16'h1000; buf_size = CW'(8);
    step_down = 1'b0; irq_mode = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 18; k++) begin
      pulse();
      gap(k % 3);
    end
    gap(3);

    // R6: half and full irq, N=8 at another aligned base
    run_off();
    dead_pulse();
    tag = "R6"; buf_base = 16'h2040; irq_mode = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 17; k++) pulse();
    gap(3);

    // R4: downward, odd N=5 (half at element 2), back-to-back syncs
    run_off();
    tag = "R4"; buf_base = 16'h0300; buf_size = CW'(5); step_down = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 12; k++) pulse();
    gap(3);

    // R8: stop mid-pass, ignore syncs, restart from offset 0
    tag = "R8"; step_down = 1'b0;
    run_off();
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) pulse();
    gap(2);
    run_off();
    dead_pulse();
    dead_pulse();
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 7; k++) pulse();
    gap(4);

    // R2: every expected strobe was produced
    check(q.size() == 0, "R2", "pending strobes", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule